// File: doc/BRIEF.md
# SMBus Clock Output Enable Controller

This block is the digital control section of a clock fan-out buffer that copies one reference clock onto six output pairs and one feedback output. A system-clock-domain SMBus slave oversamples the SCL and SDA lines, accepts block writes addressed to it, and keeps the two configuration bytes that hold the per-output enable bits. The other bytes of the block are acknowledged and then dropped.

The gating stage is asynchronous to the system clock. For each output it applies the enable bits, an active-low power-down input and a mode select. In double-data-rate mode the second output of each pair carries the inverted reference. In single-data-rate mode it carries a second in-phase copy. Enable changes pass through latches, so an output is switched on or off only while its waveform is low, and no shortened pulse reaches a clock pin.

Top module: `clkfan_ctrl`

## Requirements
- R1: Only the 7-bit address 1101001 with the write direction bit 0 (address byte 0xD2) is acknowledged. After any other address byte the slave acknowledges nothing until the next START and changes no enable bit.
- R2: A block write consists of the address byte, a command byte, a byte count and then data bytes. The slave pulls SDA low in the ninth clock of every byte, and data byte k is written to configuration index k.
- R3: Every byte is shifted in most significant bit first.
- R4: After reset every enable bit is 1, so all seven outputs toggle with the reference and SDA is released.
- R5: The mapping of enable bits is: index 7 bit 0 to pair 0, bit 2 to pair 1, bit 5 to pair 2, bit 6 to pair 3; index 6 bit 1 to pair 4, bit 3 to pair 5, bit 4 to the feedback output. All other bits have no effect on any output.
- R6: An enable bit of 1 makes its outputs follow the reference. A bit of 0 holds the true output and the feedback output low.
- R7: While pwr_dn_n is 0, all thirteen outputs are 0 regardless of the enable bits and the mode.
- R8: When ddr_mode is 1, out_c of an enabled pair is the inverse of ref_clk. When ddr_mode is 0, out_c equals out_t.
- R9: A new enable value reaches the true and feedback outputs only while ref_clk is low. An output that is high when its bit is cleared stays high until ref_clk falls.
- R10: A STOP or a repeated START in the middle of a byte discards the partial byte, and the next START begins a fresh transfer.
- R11: Data bytes beyond index 7 are acknowledged and do not change any enable bit.
- R12: sda_low changes only while SCL is low, and it is 0 outside the acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line as seen at the pin |
| sda_in | input | 1 | Serial bus data line as seen at the pin |
| sda_low | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock to be fanned out |
| pwr_dn_n | input | 1 | Active-low power-down, forces all outputs low |
| ddr_mode | input | 1 | 1: out_c is complementary; 0: out_c is an in-phase copy |
| out_t | output | 6 | True output of each pair |
| out_c | output | 6 | Second output of each pair |
| fb_out | output | 1 | Feedback copy of the reference |

## Verification
The bench scatters enable patterns across both configuration bytes and sets only reserved bits in one vector. A slave that shifted LSB first or swapped a pair's bit position would enable the wrong pairs. A slave that decoded reserved bits would disable outputs that should stay on. The bench clears the enables while the reference is high. A design that gated without a latch would chop the high phase at once, and that phase must instead run to the falling edge. A wrong address, a write running past index 7, a STOP in mid-byte and a repeated START in mid-byte each target a specific bug. A careless slave would acknowledge a foreign address, wrap a long block back onto the enable bytes, commit a half-received byte, or keep counting bits so that the following transfer lands one byte out of place.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned PAIR_CNT   = 6;
  localparam int unsigned HDR_BYTES  = 3;   // address, command, count
  localparam int unsigned EN_LO_IDX  = 6;
  localparam int unsigned EN_HI_IDX  = 7;
  localparam int unsigned FB_BIT     = 4;
  localparam logic [6:0]  SLAVE_ADDR = 7'b1101001;

  // Which configuration byte holds each pair's enable (1 = index 7).
  localparam logic [PAIR_CNT-1:0] PAIR_IN_HI = 6'b001111;
  // Bit position of each pair's enable inside its byte.
  localparam int unsigned PAIR_BIT [PAIR_CNT] = '{0, 2, 5, 6, 1, 3};

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_BITS,
    RX_DECIDE,
    RX_ACK
  } rx_state_t;

  typedef struct packed {
    logic                fb;
    logic [PAIR_CNT-1:0] pair;
  } out_en_t;

endpackage

// File: rtl/clkfan_sync.sv
module clkfan_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/clkfan_smb_rx.sv
module clkfan_smb_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  ADDR7 = SLAVE_ADDR,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_low,
  output logic              wr_stb,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);

  localparam int unsigned BIT_W = $clog2(BYTE_W);

  rx_state_t         state_q, state_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              ack_q, ack_d;
  logic              scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ack_d   = ack_q;
    wr_stb  = 1'b0;
    if (start_det) begin
      state_d = RX_BITS;
      bit_d   = '0;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_det) begin
      state_d = RX_IDLE;
      ack_d   = 1'b0;
    end else begin
      case (state_q)
        RX_BITS: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda};
            bit_d = bit_q + 1'b1;
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
              state_d = RX_DECIDE;
            end
          end
        end
        RX_DECIDE: begin
          if (scl_fall) begin
            if (cnt_q == '0) begin
              if (sh_q == {ADDR7, 1'b0}) begin
                ack_d   = 1'b1;
                state_d = RX_ACK;
              end else begin
                state_d = RX_IDLE;
              end
            end else begin
              ack_d   = 1'b1;
              state_d = RX_ACK;
              wr_stb  = (cnt_q >= CNT_W'(HDR_BYTES));
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            ack_d   = 1'b0;
            bit_d   = '0;
            state_d = RX_BITS;
            if (cnt_q != '1) begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      ack_q   <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
      scl_q   <= scl;
      sda_q   <= sda;
    end
  end

  assign sda_low = ack_q;
  assign wr_idx  = cnt_q - CNT_W'(HDR_BYTES);
  assign wr_data = sh_q;

endmodule

// File: rtl/clkfan_cfg_regs.sv
module clkfan_cfg_regs
  import clkfan_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CNT_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output out_en_t           en
);

  logic                lo_hit, hi_hit;
  logic [PAIR_CNT-1:0] pair_q, pair_d;
  logic                fb_q, fb_d;
  logic                unused_msb;

  assign lo_hit     = wr_stb && (wr_idx == CNT_W'(EN_LO_IDX));
  assign hi_hit     = wr_stb && (wr_idx == CNT_W'(EN_HI_IDX));
  assign unused_msb = wr_data[BYTE_W-1];

  for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
    if (PAIR_IN_HI[p]) begin : g_hi
      assign pair_d[p] = hi_hit ? wr_data[PAIR_BIT[p]] : pair_q[p];
    end else begin : g_lo
      assign pair_d[p] = lo_hit ? wr_data[PAIR_BIT[p]] : pair_q[p];
    end
  end

  assign fb_d = lo_hit ? wr_data[FB_BIT] : fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '1;
      fb_q   <= 1'b1;
    end else begin
      pair_q <= pair_d;
      fb_q   <= fb_d;
    end
  end

  assign en.pair = pair_q;
  assign en.fb   = fb_q;

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate
  import clkfan_pkg::*;
(
  input  logic                ref_clk,
  input  logic                pwr_dn_n,
  input  logic                ddr_mode,
  input  out_en_t             en,
  output logic [PAIR_CNT-1:0] out_t,
  output logic [PAIR_CNT-1:0] out_c,
  output logic                fb_out
);

  for (genvar p = 0; p < PAIR_CNT; p++) begin : g_ch
    logic lat_t;
    logic lat_c;

    // True side: open while the reference is low.
    always_latch begin
      if (!ref_clk) begin
        lat_t <= en.pair[p];
      end
    end

    // Complement side: open while the reference is high (its low phase).
    always_latch begin
      if (ref_clk) begin
        lat_c <= en.pair[p];
      end
    end

    assign out_t[p] = pwr_dn_n & ref_clk & lat_t;
    assign out_c[p] = pwr_dn_n & (ddr_mode ? (~ref_clk & lat_c)
                                           : (ref_clk & lat_t));
  end

  logic lat_fb;

  always_latch begin
    if (!ref_clk) begin
      lat_fb <= en.fb;
    end
  end

  assign fb_out = pwr_dn_n & ref_clk & lat_fb;

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  ADDR7 = SLAVE_ADDR,
  parameter int unsigned CNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_low,
  input  logic                ref_clk,
  input  logic                pwr_dn_n,
  input  logic                ddr_mode,
  output logic [PAIR_CNT-1:0] out_t,
  output logic [PAIR_CNT-1:0] out_c,
  output logic                fb_out
);

  logic              core_rst_n;
  logic [1:0]        bus_s;
  logic              wr_stb;
  logic [CNT_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  out_en_t           en;

  clkfan_sync #(.WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (core_rst_n)
  );

  clkfan_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     ({scl_in, sda_in}),
    .q     (bus_s)
  );

  clkfan_smb_rx #(.ADDR7(ADDR7), .CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .scl     (bus_s[1]),
    .sda     (bus_s[0]),
    .sda_low (sda_low),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  clkfan_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en      (en)
  );

  clkfan_gate u_gate (
    .ref_clk  (ref_clk),
    .pwr_dn_n (pwr_dn_n),
    .ddr_mode (ddr_mode),
    .en       (en),
    .out_t    (out_t),
    .out_c    (out_c),
    .fb_out   (fb_out)
  );

endmodule

// File: rtl/clkfan_ctrl_chk.sv
module clkfan_ctrl_chk
  import clkfan_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                scl_in,
  input logic                sda_low,
  input logic                ref_clk,
  input logic                pwr_dn_n,
  input logic                ddr_mode,
  input logic [PAIR_CNT-1:0] out_t,
  input logic [PAIR_CNT-1:0] out_c,
  input logic                fb_out
);

  assert_pwrdn_all_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> (out_t == '0) && (out_c == '0) && !fb_out)
    else $error("power-down did not silence outputs");

  assert_low_phase_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clk |-> (out_t == '0) && !fb_out)
    else $error("true output high while reference low");

  assert_ddr_comp_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && ddr_mode && ref_clk) |-> (out_c == '0))
    else $error("complement high while reference high");

  assert_sdr_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_mode |-> (out_c == out_t))
    else $error("copy output differs from true output");

  assert_no_runt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn_n && $past(pwr_dn_n) && (|(out_t & ~$past(out_t)))) |-> $rose(ref_clk))
    else $error("true output rose without a reference edge");

  assert_ack_assert_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !scl_in)
    else $error("acknowledge asserted while SCL high");

  assert_ack_release_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_low) |-> !scl_in)
    else $error("acknowledge released while SCL high");

endmodule

bind clkfan_ctrl clkfan_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_low  (sda_low),
  .ref_clk  (ref_clk),
  .pwr_dn_n (pwr_dn_n),
  .ddr_mode (ddr_mode),
  .out_t    (out_t),
  .out_c    (out_c),
  .fb_out   (fb_out)
);

// File: tb/clkfan_ctrl_test.sv
module clkfan_ctrl_test;

  localparam int Q = 6;
  localparam int H = 12;
  localparam logic [6:0] GOOD = 7'h69;

  // {byte6, byte7, 6'b0 ddr pdn, 1'b0 fb pairs[5:0]}
  localparam logic [31:0] VEC [8] = '{
    32'hFFFF037F, 32'h00FF030F, 32'hFF000170, 32'h10010341,
    32'h0864012E, 32'hE59A0300, 32'hFFFF027F, 32'h02040112
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, scl_m, sda_m, ref_clk, pwr_dn_n, ddr_mode;
  logic       sda_low, fb_out;
  logic [5:0] out_t, out_c;
  wire        sda_line = sda_m & ~sda_low;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  clkfan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_low(sda_low), .ref_clk(ref_clk), .pwr_dn_n(pwr_dn_n),
    .ddr_mode(ddr_mode), .out_t(out_t), .out_c(out_c), .fb_out(fb_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic bus_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    bus_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H / 2);
    ack = ~sda_line;
    tick(H / 2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic blk_head(input logic [6:0] a, input int n, output logic [31:0] acks);
    logic ak;
    acks = '0;
    bus_start;
    bus_byte({a, 1'b0}, ak); acks[0] = ak;
    bus_byte(8'h00, ak);     acks[1] = ak;
    bus_byte(8'(n), ak);     acks[2] = ak;
  endtask

  task automatic blk_write(input logic [6:0] a, input logic [7:0] b6, input logic [7:0] b7,
                           input int extra, output logic [31:0] acks);
    logic ak;
    blk_head(a, 8 + extra, acks);
    for (int k = 0; k < 8 + extra; k++) begin
      bus_byte((k == 6) ? b6 : ((k == 7) ? b7 : 8'h00), ak);
      acks[3 + k] = ak;
    end
    bus_stop;
    check("R12 line released after transfer", 32'(sda_low), 32'h0);
  endtask

  task automatic check_outs(input string req, input logic [6:0] exp_en,
                            input logic ddr, input logic pdn);
    logic [6:0]  e;
    logic [12:0] hi, lo, ehi, elo;
    ddr_mode = ddr; pwr_dn_n = pdn;
    ref_clk = 1'b0; tick(2);
    ref_clk = 1'b1; tick(2); hi = {fb_out, out_c, out_t};
    ref_clk = 1'b0; tick(2); lo = {fb_out, out_c, out_t};
    e   = pdn ? exp_en : 7'h00;
    ehi = {e[6], ddr ? 6'h00 : e[5:0], e[5:0]};
    elo = {1'b0, ddr ? e[5:0] : 6'h00, 6'h00};
    check({req, " ref high"}, 32'(hi), 32'(ehi));
    check({req, " ref low"},  32'(lo), 32'(elo));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] acks;
    logic [31:0] vv;
    logic        ak;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    ref_clk = 1'b0; pwr_dn_n = 1'b1; ddr_mode = 1'b1;
    tick(10);
    check("R4 sda released in reset", 32'(sda_low), 32'h0);
    rst_n = 1'b1;
    tick(5);
    check_outs("R4 reset enables", 7'h7F, 1'b1, 1'b1);

    // Vector table: R2 R3 R5 R6 R7 R8 R11 (complement parked)
    for (int v = 0; v < 8; v++) begin
      vv = VEC[v];
      blk_write(GOOD, vv[31:24], vv[23:16], 0, acks);
      check($sformatf("R2 ack pattern vec%0d", v), acks, 32'h7FF);
      check_outs($sformatf("R3 R5 R6 R7 R8 vec%0d", v), vv[6:0], vv[9], vv[8]);
    end

    // R11: bytes beyond index 7 acknowledged, discarded
    blk_write(GOOD, 8'h08, 8'h01, 8, acks);
    check("R11 extra bytes acked", acks, 32'h7FFFF);
    check_outs("R11 extra bytes discarded", 7'h21, 1'b1, 1'b1);

    // R1: wrong addresses
    blk_write(GOOD, 8'hFF, 8'hFF, 0, acks);
    blk_write(7'h68, 8'h00, 8'h00, 0, acks);
    check("R1 wrong address nack", acks, 32'h0);
    blk_write(7'h29, 8'h00, 8'h00, 0, acks);
    check("R1 wrong address msb nack", acks, 32'h0);
    check_outs("R1 no write on wrong address", 7'h7F, 1'b1, 1'b1);

    // R10: STOP inside byte 6
    blk_head(GOOD, 8, acks);
    for (int k = 0; k < 6; k++) bus_byte(8'h00, ak);
    bus_bits(8'h00, 5);
    bus_stop;
    check_outs("R10 stop aborts partial byte", 7'h7F, 1'b1, 1'b1);

    // R10: repeated START inside byte 7, then a fresh transfer
    blk_head(GOOD, 8, acks);
    for (int k = 0; k < 7; k++) bus_byte(8'hFF, ak);
    bus_bits(8'h00, 4);
    blk_write(GOOD, 8'h10, 8'h01, 0, acks);
    check("R10 repeated start ack pattern", acks, 32'h7FF);
    check_outs("R10 repeated start realigns", 7'h41, 1'b1, 1'b1);

    // R9: disable while reference high
    blk_write(GOOD, 8'hFF, 8'hFF, 0, acks);
    ddr_mode = 1'b1; pwr_dn_n = 1'b1;
    ref_clk = 1'b1; tick(2);
    blk_write(GOOD, 8'h00, 8'h00, 0, acks);
    check("R9 high phase kept", 32'({fb_out, out_c, out_t}), 32'h103F);
    ref_clk = 1'b0; tick(2);
    check("R9 parked after fall", 32'({fb_out, out_c, out_t}), 32'h0);
    ref_clk = 1'b1; tick(2);
    check("R9 stays parked", 32'({fb_out, out_c, out_t}), 32'h0);
    ref_clk = 1'b0; tick(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule